// File: doc/BRIEF.md
# Sixteen-State Add-Compare-Select Stage Unit

This block advances the path metrics of a 16-state, rate one-half, constraint-length five convolutional decoder by one trellis stage per received symbol. A symbol is a pair of signed soft values. From the pair the block forms only two branch values, their sum and their difference. The negated forms of these two cover the remaining branch labels. Metrics are correlations, so the larger candidate survives.

The update runs as eight butterflies, one per clock. Butterfly J reads the old metrics of states 2J and 2J+1 from the active bank and writes the new metrics of states J and J+8 into the other bank. When the eighth butterfly completes, the two banks exchange roles. A 16-bit decision word is then presented with a one-cycle strobe. A frame-start pulse loads the initial metrics. A combinational read port lets downstream traceback logic scan the active bank for the best final state.

Top module: `acs_stage_unit`

## Requirements
- R1: Butterfly J (0..7) produces new(J) = max(old(2J)+m, old(2J+1)-m) and new(J+8) = max(old(2J)-m, old(2J+1)+m), where m = s0+s1 for J<4 and m = s0-s1 for J>=4. The sign of m is reversed in both expressions for odd J.
- R2: Candidates are compared as signed 16-bit values. The path from state 2J is kept, with decision 0, only when it is strictly greater; otherwise the path from 2J+1 is kept, with decision 1, so ties give 1.
- R3: Decisions enter the word from the LSB side, two per butterfly (state J first, then J+8). The finished word therefore holds states 0,8,1,9,...,7,15 from bit 15 down to bit 0.
- R4: Each candidate sum saturates to the range -32768..32767 and never wraps.
- R5: Reset and a frame_start pulse set state 0 of the active bank to 0 and all other states to -32768 (16'h8000). A frame_start pulse also abandons any stage in progress.
- R6: A symbol is accepted when sym_valid and sym_ready are both high. sym_ready is low while a stage runs. dec_valid is a single-cycle pulse, raised on the eighth rising edge after the accepting edge.
- R7: rd_metric shows the metric of state rd_state in the active bank. It keeps showing the old stage while the butterflies run and switches to the new stage in the cycle dec_valid is high.
- R8: When the new state-0 metric of a stage exceeds NORM_TH (16384 by default), that value is subtracted, with saturation, from all 16 new metrics before the banks swap. At a strobe, state 0 never exceeds NORM_TH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frame_start | input | 1 | Loads initial metrics, cancels a running stage |
| sym_valid | input | 1 | Symbol pair present |
| sym_ready | output | 1 | Block can accept a symbol |
| sd0 | input | SD_W | First signed soft value |
| sd1 | input | SD_W | Second signed soft value |
| dec_valid | output | 1 | Decision word strobe |
| dec_word | output | 16 | Packed survivor decisions |
| rd_state | input | 4 | State index for metric read |
| rd_metric | output | MW | Signed metric of rd_state in the active bank |

## Verification
The hardest condition to reach is renormalisation. State 0 must climb past the threshold, and it gains at most a few hundred per stage. The bench therefore drives a long run of the same maximum-confidence symbol so that the state-0 path gains every stage. It compares every metric against a bench model after each stage, across the stage where the subtraction happens. Saturation is reached from the frame-start metrics, where subtracting a branch value from -32768 would otherwise wrap.

// File: rtl/acs_stage_unit.sv
module acs_stage_unit #(
  parameter int SD_W = 8,
  parameter int MW = 16,
  parameter logic signed [MW-1:0] NORM_TH = 16384
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_start,
  input  logic                 sym_valid,
  output logic                 sym_ready,
  input  logic signed [SD_W-1:0] sd0,
  input  logic signed [SD_W-1:0] sd1,
  output logic                 dec_valid,
  output logic [15:0]          dec_word,
  input  logic [3:0]           rd_state,
  output logic signed [MW-1:0] rd_metric
);
  localparam int NS = 16;
  localparam logic signed [MW-1:0] MNEG = {1'b1, {(MW-1){1'b0}}};
  localparam logic signed [MW-1:0] MPOS = {1'b0, {(MW-1){1'b1}}};

  logic signed [MW-1:0] bank [2][NS];
  logic sel, busy, norm;
  logic [2:0] bfly;
  logic signed [MW-1:0] m_sum, m_diff, off;

  function automatic logic signed [MW-1:0] sat(input logic signed [MW:0] s);
    if (s[MW] != s[MW-1]) return s[MW] ? MNEG : MPOS;
    return s[MW-1:0];
  endfunction

  function automatic logic signed [MW:0] ext(input logic signed [MW-1:0] v);
    return {v[MW-1], v};
  endfunction

  logic signed [MW-1:0] m, ms, o_e, o_o, ca0, ca1, cb0, cb1, na, nb;
  logic da, db;

  assign sym_ready = !busy;
  assign rd_metric = bank[sel][rd_state];

  always_comb begin
    m   = bfly[2] ? m_diff : m_sum;
    ms  = bfly[0] ? -m : m;
    o_e = bank[sel][{bfly, 1'b0}];
    o_o = bank[sel][{bfly, 1'b1}];
    ca0 = sat(ext(o_e) + ext(ms));
    ca1 = sat(ext(o_o) - ext(ms));
    cb0 = sat(ext(o_e) - ext(ms));
    cb1 = sat(ext(o_o) + ext(ms));
    da  = !(ca0 > ca1);
    db  = !(cb0 > cb1);
    na  = da ? ca1 : ca0;
    nb  = db ? cb1 : cb0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < NS; i++)
          bank[b][i] <= (i == 0) ? '0 : MNEG;
      sel <= 1'b0;
      busy <= 1'b0;
      bfly <= '0;
      norm <= 1'b0;
      off <= '0;
      m_sum <= '0;
      m_diff <= '0;
      dec_valid <= 1'b0;
      dec_word <= '0;
    end else begin
      dec_valid <= 1'b0;
      if (frame_start) begin
        busy <= 1'b0;
        bfly <= '0;
        for (int i = 0; i < NS; i++)
          bank[sel][i] <= (i == 0) ? '0 : MNEG;
      end else if (sym_valid && !busy) begin
        busy   <= 1'b1;
        bfly   <= '0;
        m_sum  <= MW'(sd0) + MW'(sd1);
        m_diff <= MW'(sd0) - MW'(sd1);
      end else if (busy) begin
        bank[!sel][{1'b0, bfly}] <= na;
        bank[!sel][{1'b1, bfly}] <= nb;
        dec_word <= {dec_word[13:0], da, db};
        bfly <= bfly + 3'd1;
        if (bfly == 3'd0) begin
          norm <= na > NORM_TH;
          off  <= na;
        end
        if (bfly == 3'd7) begin
          busy <= 1'b0;
          dec_valid <= 1'b1;
          sel <= !sel;
          if (norm)
            for (int i = 0; i < NS; i++)
              bank[!sel][i] <= sat(ext((i == 7) ? na : (i == 15) ? nb : bank[!sel][i]) - ext(off));
        end
      end
    end
  end

  assert_strobe_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);
  assert_busy_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_ready && !frame_start) |=> !sym_ready);
  assert_bounded_state0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (bank[sel][0] <= NORM_TH));
  assert_frame_init_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (bank[sel][0] == '0 && bank[sel][1] == MNEG && bank[sel][15] == MNEG));
  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && o_o == MNEG && ms > 0) |-> (ca1 == MNEG));
endmodule

// File: tb/acs_stage_unit_bench.sv
module acs_stage_unit_bench;
  logic clk = 1'b0, rst_n = 1'b0, frame_start = 1'b0, sym_valid = 1'b0;
  logic sym_ready, dec_valid;
  logic signed [7:0] sd0 = '0, sd1 = '0;
  logic [15:0] dec_word;
  logic [3:0] rd_state = '0;
  logic signed [15:0] rd_metric;
  int total = 0, bad = 0;
  int om [16];
  int lat;
  logic [15:0] wd;

  acs_stage_unit u_acs_stage_unit (.clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .sym_valid(sym_valid), .sym_ready(sym_ready), .sd0(sd0), .sd1(sd1),
    .dec_valid(dec_valid), .dec_word(dec_word), .rd_state(rd_state), .rd_metric(rd_metric));

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > 32767) ? 32767 : (v < -32768) ? -32768 : v;
  endfunction

  function automatic void model_init();
    for (int i = 0; i < 16; i++) om[i] = (i == 0) ? 0 : -32768;
  endfunction

  function automatic logic [15:0] model_step(input int s0, input int s1);
    int nm [16];
    int m, a0, a1, b0, b1, off;
    logic [15:0] w = '0;
    for (int j = 0; j < 8; j++) begin
      m = (j < 4) ? s0 + s1 : s0 - s1;
      if (j % 2 == 1) m = -m;
      a0 = sat(om[2*j] + m); a1 = sat(om[2*j+1] - m);
      b0 = sat(om[2*j] - m); b1 = sat(om[2*j+1] + m);
      nm[j]   = (a0 > a1) ? a0 : a1;
      nm[j+8] = (b0 > b1) ? b0 : b1;
      w = {w[13:0], !(a0 > a1), !(b0 > b1)};
    end
    off = nm[0];
    for (int i = 0; i < 16; i++) om[i] = (off > 16384) ? sat(nm[i] - off) : nm[i];
    return w;
  endfunction

  task automatic compare_bank(input string req);
    for (int i = 0; i < 16; i++) begin
      rd_state = 4'(i);
      #1;
      check(req, int'(rd_metric), om[i]);
    end
  endtask

  task automatic send(input int s0, input int s1);
    @(negedge clk);
    sd0 = 8'(s0); sd1 = 8'(s1); sym_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sym_valid = 1'b0;
    lat = 1;
    while (!dec_valid) begin
      @(negedge clk);
      lat++;
    end
    wd = dec_word;
  endtask

  task automatic do_frame();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    model_init();
  endtask

  task automatic t_reset();
    check("R6 ready after reset", int'(sym_ready), 1);
    check("R6 no strobe after reset", int'(dec_valid), 0);
    model_init();
    compare_bank("R5 reset metrics");
  endtask

  task automatic t_timing();
    do_frame();
    rd_state = 4'd8;
    @(negedge clk);
    sd0 = 8'sd10; sd1 = 8'sd3; sym_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sym_valid = 1'b0;
    check("R6 ready low while busy", int'(sym_ready), 0);
    check("R7 old metric during stage", int'(rd_metric), -32768);
    lat = 1;
    while (!dec_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check("R6 strobe latency", lat, 9);
    wd = model_step(10, 3);
    check("R3 decision word", int'(dec_word), int'(wd));
    #1;
    check("R7 new metric at strobe", int'(rd_metric), om[8]);
    @(negedge clk);
    check("R6 strobe single pulse", int'(dec_valid), 0);
    check("R6 ready after stage", int'(sym_ready), 1);
    compare_bank("R1 metrics after stage");
  endtask

  task automatic t_tie();
    do_frame();
    send(0, 0);
    check("R2 tie word", int'(wd), 16'h3FFF);
    void'(model_step(0, 0));
    compare_bank("R2 tie metrics");
  endtask

  task automatic t_sat();
    do_frame();
    send(-100, -100);
    void'(model_step(-100, -100));
    rd_state = 4'd9;
    #1;
    check("R4 no wrap state 9", int'(rd_metric), -32568);
    rd_state = 4'd8;
    #1;
    check("R4 state 8", int'(rd_metric), 200);
    compare_bank("R4 metrics");
  endtask

  task automatic t_sequence();
    logic [15:0] e;
    do_frame();
    for (int i = 0; i < 12; i++) begin
      int a = ((i * 37) % 256) - 128;
      int b = ((i * 91 + 50) % 256) - 128;
      send(a, b);
      e = model_step(a, b);
      check("R3 word in sequence", int'(wd), int'(e));
      compare_bank("R1 sequence metrics");
    end
  endtask

  task automatic t_norm();
    logic [15:0] e;
    do_frame();
    for (int i = 0; i < 80; i++) begin
      send(127, 127);
      e = model_step(127, 127);
      check("R3 word long run", int'(wd), int'(e));
      rd_state = 4'd0;
      #1;
      check("R8 state0 bounded", int'(rd_metric <= 16'sd16384), 1);
    end
    compare_bank("R8 metrics after renormalisation");
  endtask

  task automatic t_restart();
    @(negedge clk);
    sd0 = 8'sd50; sd1 = -8'sd20; sym_valid = 1'b1;
    @(negedge clk);
    sym_valid = 1'b0;
    repeat (2) @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    model_init();
    check("R5 ready after restart", int'(sym_ready), 1);
    repeat (10) begin
      @(negedge clk);
      check("R5 no strobe after restart", int'(dec_valid), 0);
    end
    compare_bank("R5 restart metrics");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timing();
    t_tie();
    t_sat();
    t_sequence();
    t_norm();
    t_restart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule